// File: doc/BRIEF.md
# I2C Bit-Clock Tick Generator

This block derives the timing base for an I2C master from a fast system clock. A seven-bit setting word carries two divider fields, an exponent N and a multiplier M. The block emits a single-cycle pulse, `tick_o`, at ten times the intended SCL rate. The bit engine counts these pulses to step through the SCL low and high phases.

The divider is built as two stages. A power-of-two prescaler feeds a modulo-(M+1) counter, and each wrap of the second stage produces one tick. A strap input chooses between two divider bases. With the strap low, the prescaler divides by 2^(N+1). With the strap high, it divides by 2^N. The strap is captured together with the setting word.

A new setting takes effect when it is loaded, and loading restarts both stages from zero. The first tick after a load therefore comes one full period later. All pins are plain control and status signals. The block has no streaming interface and no back-pressure.

Top module: `i2c_baud_tick`

## Requirements
- R1: A pulse on `cfg_load_i` captures N from `cfg_word_i[2:0]`, M from `cfg_word_i[6:3]`, and the strap value `alt_base_i`. All three take effect at that clock edge.
- R2: With the captured strap low, `tick_o` is high for one cycle out of every (M+1)·2^(N+1) cycles.
- R3: With the captured strap high, `tick_o` is high for one cycle out of every (M+1)·2^N cycles. When N=0 and M=0 this means `tick_o` is high on every cycle.
- R4: A load restarts both stages from zero, whatever their phase. `tick_o` is low in the cycle after the load edge, and the first tick appears exactly one full period after that edge. No shortened interval occurs.
- R5: A synchronous reset (`rst_i` high at a clock edge) clears both stages and holds `tick_o` low while reset is applied and in the cycle after the last reset edge. Reset sets M=0 and N=0 and captures the strap.
- R6: Whenever the period exceeds one cycle, each tick lasts exactly one cycle and is followed by a low cycle.
- R7: Changing `alt_base_i` without a load has no effect, and the tick spacing continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| alt_base_i | input | 1 | Divider-base strap: 0 selects 2^(N+1), 1 selects 2^N |
| cfg_word_i | input | 7 | Setting word: N in [2:0], M in [6:3] |
| cfg_load_i | input | 1 | One-cycle strobe that captures the setting and restarts the divider |
| tick_o | output | 1 | One-cycle pulse at ten times the SCL rate |

## Verification
Several properties are checked on every cycle by the assertions:
- the prescaler counter steps by one or wraps;
- the second stage holds unless the prescaler enables it;
- a tick is always preceded by a prescaler enable;
- `tick_o` is low right after a load and right after reset;
- ticks are never back to back unless the period is one cycle.

Other behaviour can only be shown by the bench's scenarios, because the assertions do not capture it:
- the exact period for every M, N and strap combination;
- the placement of the first tick after a load, including a reload in the middle of a phase;
- the reset default;
- the fact that changing the strap alone does not alter the spacing.

// File: rtl/i2c_baud_pkg.sv
package i2c_baud_pkg;
  localparam int DEF_N_W = 3;
  localparam int DEF_M_W = 4;

  typedef enum logic {
    BASE_TWO = 1'b0,  // prescale by 2^(N+1)
    BASE_ONE = 1'b1   // prescale by 2^N
  } base_sel_e;
endpackage

// File: rtl/i2c_baud_cfg.sv
module i2c_baud_cfg
  import i2c_baud_pkg::*;
#(
  parameter int N_W = DEF_N_W,
  parameter int M_W = DEF_M_W,
  localparam int CFG_W = N_W + M_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             alt_base_i,
  input  logic [CFG_W-1:0] cfg_word_i,
  input  logic             cfg_load_i,
  output logic [N_W-1:0]   n_o,
  output logic [M_W-1:0]   m_o,
  output base_sel_e        base_o,
  output logic             restart_o
);
  logic [N_W-1:0] n_q;
  logic [M_W-1:0] m_q;
  base_sel_e      base_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      n_q    <= '0;
      m_q    <= '0;
      base_q <= base_sel_e'(alt_base_i);
    end else if (cfg_load_i) begin
      n_q    <= cfg_word_i[N_W-1:0];
      m_q    <= cfg_word_i[CFG_W-1:N_W];
      base_q <= base_sel_e'(alt_base_i);
    end
  end

  assign restart_o = cfg_load_i & ~rst_i;
  assign n_o       = n_q;
  assign m_o       = m_q;
  assign base_o    = base_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && !$past(cfg_load_i) |-> $stable(n_q) && $stable(m_q) && $stable(base_q)); // R7
endmodule

// File: rtl/i2c_baud_prescale.sv
module i2c_baud_prescale
  import i2c_baud_pkg::*;
#(
  parameter int N_W = DEF_N_W,
  localparam int PRE_W = 1 << N_W,
  localparam int EXP_W = N_W + 1
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           restart_i,
  input  logic [N_W-1:0] n_i,
  input  base_sel_e      base_i,
  output logic           pre_en_o
);
  logic [EXP_W-1:0] exp_w;
  logic [PRE_W-1:0] last_w;
  logic [PRE_W-1:0] cnt_q;

  always_comb begin
    if (base_i == BASE_ONE) exp_w = {1'b0, n_i};
    else                    exp_w = {1'b0, n_i} + EXP_W'(1);
    last_w = ~({PRE_W{1'b1}} << exp_w);
  end

  assign pre_en_o = (cnt_q == last_w);

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) cnt_q <= '0;
    else if (pre_en_o)      cnt_q <= '0;
    else                    cnt_q <= cnt_q + PRE_W'(1);
  end

  AST_PRE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && !$past(restart_i) && !$past(pre_en_o) |-> cnt_q == $past(cnt_q) + PRE_W'(1)); // R2
  AST_PRE_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && $past(pre_en_o) |-> cnt_q == '0); // R3
endmodule

// File: rtl/i2c_baud_modulo.sv
module i2c_baud_modulo
  import i2c_baud_pkg::*;
#(
  parameter int M_W = DEF_M_W
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           restart_i,
  input  logic           pre_en_i,
  input  logic [M_W-1:0] m_i,
  output logic           tick_o
);
  logic [M_W-1:0] cnt_q;
  logic           tick_q;
  logic           wrap_w;
  logic           rst_d_q;

  assign wrap_w = pre_en_i && (cnt_q == m_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap_w;
      if (pre_en_i) cnt_q <= wrap_w ? '0 : cnt_q + M_W'(1);
    end
  end

  always_ff @(posedge clk_i) rst_d_q <= rst_i;

  assign tick_o = tick_q;

  always_comb begin
    if (rst_d_q) AST_RST_QUIET: assert (!tick_q); // R5
  end

  AST_TICK_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_q |-> $past(pre_en_i)); // R2
  AST_STAGE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && !$past(restart_i) && !$past(pre_en_i) |-> $stable(cnt_q)); // R3
  AST_LOAD_CLEAN: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |=> !tick_q); // R4
endmodule

// File: rtl/i2c_baud_tick.sv
module i2c_baud_tick
  import i2c_baud_pkg::*;
#(
  parameter int N_W = DEF_N_W,
  parameter int M_W = DEF_M_W,
  localparam int CFG_W = N_W + M_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             alt_base_i,
  input  logic [CFG_W-1:0] cfg_word_i,
  input  logic             cfg_load_i,
  output logic             tick_o
);
  logic [N_W-1:0] n_w;
  logic [M_W-1:0] m_w;
  base_sel_e      base_w;
  logic           restart_w;
  logic           pre_en_w;
  logic           unit_w;

  i2c_baud_cfg #(.N_W(N_W), .M_W(M_W)) cfg_i (
    .clk_i(clk_i), .rst_i(rst_i), .alt_base_i(alt_base_i),
    .cfg_word_i(cfg_word_i), .cfg_load_i(cfg_load_i),
    .n_o(n_w), .m_o(m_w), .base_o(base_w), .restart_o(restart_w)
  );

  i2c_baud_prescale #(.N_W(N_W)) pre_i (
    .clk_i(clk_i), .rst_i(rst_i), .restart_i(restart_w),
    .n_i(n_w), .base_i(base_w), .pre_en_o(pre_en_w)
  );

  i2c_baud_modulo #(.M_W(M_W)) mod_i (
    .clk_i(clk_i), .rst_i(rst_i), .restart_i(restart_w),
    .pre_en_i(pre_en_w), .m_i(m_w), .tick_o(tick_o)
  );

  assign unit_w = (base_w == BASE_ONE) && (n_w == '0) && (m_w == '0);

  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o && !unit_w |=> !tick_o); // R6
endmodule

// File: tb/i2c_baud_tick_tb.sv
module i2c_baud_tick_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alt = 1'b0;
  logic [6:0] word = '0;
  logic       load = 1'b0;
  logic       tick;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;  // 250 MHz

  i2c_baud_tick dut_i (
    .clk_i(clk), .rst_i(rst), .alt_base_i(alt),
    .cfg_word_i(word), .cfg_load_i(load), .tick_o(tick)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: tick=%b expected %b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // load a setting; sample the cycle right after the load edge (R4)
  task automatic load_cfg(input int m, input int n, input logic a);
    @(negedge clk);
    word = 7'((m << 3) | n);
    alt  = a;
    load = 1'b1;
    @(posedge clk); #1;
    chk(tick, 1'b0, "R4 no tick after load");
    @(negedge clk);
    load = 1'b0;
  endtask

  // observe cycles j0..j1 after the restart edge, tick expected when j%p==0
  task automatic watch(input int p, input int j0, input int j1, input string tag);
    for (int j = j0; j <= j1; j++) begin
      @(posedge clk); #1;
      chk(tick, (j % p) == 0, tag);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (expected completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R5: reset state and default setting M=0 N=0 (period 2, strap low)
    repeat (3) begin
      @(posedge clk); #1;
      chk(tick, 1'b0, "R5 tick low in reset");
    end
    @(negedge clk) rst = 1'b0;
    watch(2, 1, 6, "R5 reset default period");

    // R1/R2/R3: full sweep of both bases, one period each
    for (int a = 0; a < 2; a++)
      for (int n = 0; n < 8; n++)
        for (int m = 0; m < 16; m++) begin
          int p;
          p = (m + 1) * ((a == 0) ? (2 << n) : (1 << n));
          load_cfg(m, n, logic'(a));
          if (a == 0) watch(p, 1, p, "R1/R2 sweep default base");
          else        watch(p, 1, p, "R1/R3 sweep alternate base");
        end

    // R3: unit period, tick high every cycle
    load_cfg(0, 0, 1'b1);
    watch(1, 1, 8, "R3 unit period");

    // R6: several periods, pulse one cycle wide
    load_cfg(2, 1, 1'b0);
    watch(12, 1, 36, "R6 repeated pulses");
    load_cfg(0, 1, 1'b1);
    watch(2, 1, 10, "R6 short period");

    // R4: reload mid-phase with the same and with a different setting
    load_cfg(5, 1, 1'b0);
    watch(24, 1, 10, "R4 before reload");
    load_cfg(5, 1, 1'b0);
    watch(24, 1, 48, "R4 restart same");
    load_cfg(3, 2, 1'b0);
    watch(32, 1, 20, "R4 before change");
    load_cfg(1, 0, 1'b1);
    watch(2, 1, 8, "R4 restart new");

    // R7: strap change without load has no effect
    load_cfg(1, 2, 1'b0);
    watch(16, 1, 5, "R7 before strap flip");
    alt = 1'b1;
    watch(16, 6, 48, "R7 strap ignored");

    // R5: reset mid-run, then default period with strap low
    load_cfg(3, 0, 1'b0);
    watch(8, 1, 5, "R5 before reset");
    @(negedge clk);
    alt = 1'b0;
    rst = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      chk(tick, 1'b0, "R5 tick low in reset");
    end
    @(negedge clk) rst = 1'b0;
    watch(2, 1, 6, "R5 default after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule